// File: doc/BRIEF.md
# PWM Fault Protection Controller

This block sits between two external fault inputs and a six-channel PWM generator. It decides which PWM channels must be held off. Each fault input goes through a short synchronous qualifier that rejects glitches. The qualifier needs a low sample first, then two high samples in a row. A qualified fault drives a live status bit for as long as it lasts, and it sets a sticky event flag that software clears with a one-clock strobe.

A software-owned mask for each fault input selects the channels that the fault shuts off. The disable vector is the OR of the masks of all faults whose shutdown is still held. Each input has its own mode bit, which selects how the held shutdown is released.

- **Automatic mode:** the hold is released by the pin itself, at the first PWM period start after the fault has gone away.
- **Manual mode:** software must also have cleared the sticky flag before that period start.

A fault pin whose shared port bit is configured as an output is read as fault-free.

Top module: `pwmfp_guard`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `fault_live`, `fault_flag` and `pwm_disable` are all zero. After reset, an input that has never been sampled low cannot raise a fault, even if it is held high.
- R2: Once an input has been sampled low at least once, two consecutive clocks that sample it high (and not forced) set `fault_live[i]` and `fault_flag[i]` on the second of those edges. A single high sample between low samples sets nothing.
- R3: `fault_live[i]` clears on the first clock edge that samples the input low.
- R4: While `port_is_out[i]` is 1, input i is treated as low, whatever level its pin has.
- R5: A one-cycle pulse on `flag_clr[i]` clears `fault_flag[i]` on that edge. If a new qualified fault arrives on the same edge, the flag stays set.
- R6: `map_mask[6*i+5:6*i]` is the channel mask of fault input i, with bit c of the slice standing for channel c. `pwm_disable[c]` is 1 exactly when some input with a held shutdown has bit c set in its mask. The output follows mask changes without waiting for a clock.
- R7: The shutdown of input i is taken on the same edge on which `fault_live[i]` rises. It is released only on an edge where `cycle_start` is 1 and `fault_live[i]` was already 0 before that edge.
- R8: In automatic mode (`auto_mode[i]` = 1), clearing `fault_flag[i]` has no effect on the held shutdown.
- R9: In manual mode (`auto_mode[i]` = 0), the held shutdown is released only at a `cycle_start` edge where, before that edge, `fault_flag[i]` is already 0 and `fault_live[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_pin | input | 2 | Fault inputs, high means fault, synchronous to clk |
| port_is_out | input | 2 | Shared port bit configured as output; forces that input fault-free |
| auto_mode | input | 2 | 1 = automatic re-enable, 0 = manual re-enable |
| map_mask | input | 12 | Per-input channel mask, 6 bits per input, input 0 in the low bits |
| flag_clr | input | 2 | One-cycle clear strobe for each sticky flag |
| cycle_start | input | 1 | One-cycle pulse at each PWM period boundary |
| fault_live | output | 2 | Qualified fault currently present |
| fault_flag | output | 2 | Sticky fault event flag |
| pwm_disable | output | 6 | Per-channel disable, 1 = channel forced off |

## Verification
On every cycle, the assertions check the following:
- the forced-input rule;
- the pairing of a rising live bit with its flag;
- the precedence of a flag set over a flag clear;
- that a live fault always has its mapped channels disabled;
- that a hold is only ever dropped at a period start after the fault is gone, and in manual mode only once the flag was already clear.

The bench scenarios show the sequence-dependent behaviour:
- the low-first arming after reset;
- the rejection of a lone high sample;
- the exact release edge in each mode;
- overlapping faults that share a channel;
- mask changes taking effect without a clock edge.

// File: rtl/pwmfp_pkg.sv
package pwmfp_pkg;

  // qualifier state of one fault input
  typedef enum logic [1:0] {
    QS_NEED_LOW = 2'd0,   // not yet seen a low sample
    QS_ARMED    = 2'd1,   // low seen, waiting for first high
    QS_ONE_HIGH = 2'd2,   // one high sample taken
    QS_FAULT    = 2'd3    // qualified fault present
  } qual_state_e;

  // next qualifier state from the current state and the sampled level
  function automatic qual_state_e qual_next(input qual_state_e cur, input logic lvl);
    qual_state_e nxt;
    unique case (cur)
      QS_NEED_LOW: nxt = lvl ? QS_NEED_LOW : QS_ARMED;
      QS_ARMED:    nxt = lvl ? QS_ONE_HIGH : QS_ARMED;
      QS_ONE_HIGH: nxt = lvl ? QS_FAULT    : QS_ARMED;
      default:     nxt = lvl ? QS_FAULT    : QS_ARMED;
    endcase
    return nxt;
  endfunction

  // a new qualified fault is accepted on this edge
  function automatic logic qual_accept(input qual_state_e cur, input logic lvl);
    return (cur == QS_ONE_HIGH) && lvl;
  endfunction

  // condition under which a held shutdown may be released on this edge
  function automatic logic release_ok(input logic live_q, input logic flag_q,
                                      input logic auto_m, input logic period_go);
    return period_go && !live_q && (auto_m || !flag_q);
  endfunction

  // sticky flag next value: a set takes priority over a clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

endpackage

// File: rtl/pwmfp_qualifier.sv
module pwmfp_qualifier
  import pwmfp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_lvl,
  input  logic force_quiet,
  output logic live,
  output logic accept
);

  qual_state_e state_q;
  logic        lvl_eff;

  // a port bit driven as output hides the pin from the qualifier
  assign lvl_eff = pin_lvl && !force_quiet;
  assign accept  = qual_accept(state_q, lvl_eff);
  assign live    = (state_q == QS_FAULT);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= QS_NEED_LOW;
    else        state_q <= qual_next(state_q, lvl_eff);
  end

endmodule

// File: rtl/pwmfp_recovery.sv
module pwmfp_recovery
  import pwmfp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic live,
  input  logic auto_m,
  input  logic clr,
  input  logic period_go,
  output logic flag,
  output logic hold
);

  logic flag_q, hold_q;
  logic drop;

  assign drop = hold_q && release_ok(live, flag_q, auto_m, period_go);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, accept, clr);
      if (accept)    hold_q <= 1'b1;
      else if (drop) hold_q <= 1'b0;
    end
  end

  assign flag = flag_q;
  assign hold = hold_q;

endmodule

// File: rtl/pwmfp_mapper.sv
module pwmfp_mapper #(
  parameter int N_IN = 2,
  parameter int N_CH = 6
) (
  input  logic [N_IN-1:0]      hold_vec,
  input  logic [N_IN*N_CH-1:0] masks,
  output logic [N_CH-1:0]      disable_vec
);

  // channel c is off when any held input lists it in its mask
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [N_IN-1:0] hits;
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign hits[i] = hold_vec[i] && masks[i*N_CH + c];
    end
    assign disable_vec[c] = |hits;
  end

endmodule

// File: rtl/pwmfp_guard.sv
module pwmfp_guard #(
  parameter int N_IN = 2,
  parameter int N_CH = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_IN-1:0]      fault_pin,
  input  logic [N_IN-1:0]      port_is_out,
  input  logic [N_IN-1:0]      auto_mode,
  input  logic [N_IN*N_CH-1:0] map_mask,
  input  logic [N_IN-1:0]      flag_clr,
  input  logic                 cycle_start,
  output logic [N_IN-1:0]      fault_live,
  output logic [N_IN-1:0]      fault_flag,
  output logic [N_CH-1:0]      pwm_disable
);

  // internal events brought out for the checker
  logic [N_IN-1:0] fault_set;
  logic [N_IN-1:0] hold_vec;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    pwmfp_qualifier u_qual (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_lvl     (fault_pin[i]),
      .force_quiet (port_is_out[i]),
      .live        (fault_live[i]),
      .accept      (fault_set[i])
    );

    pwmfp_recovery u_rec (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (fault_set[i]),
      .live      (fault_live[i]),
      .auto_m    (auto_mode[i]),
      .clr       (flag_clr[i]),
      .period_go (cycle_start),
      .flag      (fault_flag[i]),
      .hold      (hold_vec[i])
    );
  end

  pwmfp_mapper #(.N_IN(N_IN), .N_CH(N_CH)) u_map (
    .hold_vec    (hold_vec),
    .masks       (map_mask),
    .disable_vec (pwm_disable)
  );

endmodule

// File: rtl/pwmfp_guard_chk.sv
module pwmfp_guard_chk #(
  parameter int N_IN = 2,
  parameter int N_CH = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_IN-1:0]      fault_pin,
  input logic [N_IN-1:0]      port_is_out,
  input logic [N_IN-1:0]      auto_mode,
  input logic [N_IN*N_CH-1:0] map_mask,
  input logic [N_IN-1:0]      flag_clr,
  input logic                 cycle_start,
  input logic [N_IN-1:0]      fault_live,
  input logic [N_IN-1:0]      fault_flag,
  input logic [N_CH-1:0]      pwm_disable,
  input logic [N_IN-1:0]      fault_set,
  input logic [N_IN-1:0]      hold_vec
);

  for (genvar i = 0; i < N_IN; i++) begin : g_chk
    // R2: a rising live bit comes with its flag and a real high level
    a_r2_live_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_live[i]) |-> fault_flag[i] && $past(fault_pin[i] && !port_is_out[i]));

    // R3: a low sample drops the live bit
    a_r3_low_clears_live: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_live[i] && !fault_pin[i]) |=> !fault_live[i]);

    // R4: a port configured as output hides the pin
    a_r4_forced_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      port_is_out[i] |=> !fault_live[i]);

    // R5: clear strobe works unless a set arrives on the same edge
    a_r5_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[i] && !fault_set[i]) |=> !fault_flag[i]);
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      fault_set[i] |=> fault_flag[i]);

    // R6: a live fault always has its mapped channels off
    a_r6_live_masked: assert property (@(posedge clk) disable iff (!rst_n)
      fault_live[i] |-> ((pwm_disable & map_mask[i*N_CH +: N_CH]) == map_mask[i*N_CH +: N_CH]));

    // R7: a hold is dropped only at a period start after the fault is gone
    a_r7_release_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_vec[i]) |-> $past(cycle_start) && !$past(fault_live[i]));

    // R9: in manual mode the flag must be clear before the release
    a_r9_manual_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hold_vec[i]) && !$past(auto_mode[i])) |-> !$past(fault_flag[i]));
  end

endmodule

bind pwmfp_guard pwmfp_guard_chk #(.N_IN(N_IN), .N_CH(N_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fault_pin   (fault_pin),
  .port_is_out (port_is_out),
  .auto_mode   (auto_mode),
  .map_mask    (map_mask),
  .flag_clr    (flag_clr),
  .cycle_start (cycle_start),
  .fault_live  (fault_live),
  .fault_flag  (fault_flag),
  .pwm_disable (pwm_disable),
  .fault_set   (fault_set),
  .hold_vec    (hold_vec)
);

// File: tb/tb_pwmfp_guard.sv
module tb_pwmfp_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fault_pin, port_is_out, auto_mode, flag_clr;
  logic [11:0] map_mask;
  logic        cycle_start;
  logic [1:0]  fault_live, fault_flag;
  logic [5:0]  pwm_disable;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmfp_guard dut (
    .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .port_is_out(port_is_out),
    .auto_mode(auto_mode), .map_mask(map_mask), .flag_clr(flag_clr),
    .cycle_start(cycle_start), .fault_live(fault_live), .fault_flag(fault_flag),
    .pwm_disable(pwm_disable)
  );

  // row layout: pin[16:15] dir[14:13] clr[12:11] cs[10] live[9:8] flag[7:6] dis[5:0]
  // masks: input0 -> 000111, input1 -> 110100; input0 automatic, input1 manual
  localparam logic [16:0] VEC [NV] = '{
    17'b00_00_00_0_00_00_000000, //  0 R2 arm both
    17'b01_00_00_0_00_00_000000, //  1 R2 one high
    17'b00_00_00_0_00_00_000000, //  2 R2 lone high rejected
    17'b01_00_00_0_00_00_000000, //  3 R2 first high
    17'b01_00_00_0_01_01_000111, //  4 R2 R7 fault and immediate disable
    17'b01_00_00_1_01_01_000111, //  5 R7 period start while live
    17'b00_00_00_0_00_01_000111, //  6 R3 live clears, hold kept
    17'b00_00_01_0_00_00_000111, //  7 R5 R8 clearing flag does not release
    17'b00_00_00_1_00_00_000000, //  8 R7 automatic release
    17'b10_00_00_0_00_00_000000, //  9 R2 input1 first high
    17'b10_00_00_0_10_10_110100, // 10 R2 R6 input1 fault
    17'b00_00_00_0_00_10_110100, // 11 R3
    17'b00_00_00_1_00_10_110100, // 12 R9 flag still set, no release
    17'b00_00_10_0_00_00_110100, // 13 R5 clear flag
    17'b00_00_00_1_00_00_000000, // 14 R9 manual release
    17'b11_00_00_0_00_00_000000, // 15 both first high
    17'b11_00_00_0_11_11_110111, // 16 R6 overlap
    17'b01_00_00_1_01_11_110111, // 17 R7 live was high before edge
    17'b01_00_10_1_01_01_110111, // 18 R9 clear and start together, no release
    17'b01_00_00_1_01_01_000111, // 19 R9 input1 released, input0 held
    17'b00_00_00_1_00_01_000111, // 20 R7 input0 live was high before edge
    17'b00_00_00_1_00_01_000000, // 21 R7 R8 release with flag still set
    17'b01_01_00_0_00_01_000000, // 22 R4 forced quiet
    17'b01_01_00_0_00_01_000000, // 23 R4 still quiet
    17'b01_00_00_0_00_01_000000, // 24 R2 unforced first high
    17'b01_00_01_0_01_01_000111, // 25 R5 set wins over clear
    17'b01_01_00_0_00_01_000111, // 26 R4 forcing drops live
    17'b00_00_00_1_00_01_000000, // 27 R7 release
    17'b00_00_01_0_00_00_000000  // 28 R5 clear
  };

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fault_pin = 2'b00; port_is_out = 2'b00; flag_clr = 2'b00; cycle_start = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] pins);
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    fault_pin = pins;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "outputs in reset", {6'd0, fault_live, fault_flag, pwm_disable}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    auto_mode = 2'b01;
    map_mask = {6'b110100, 6'b000111};
    idle_inputs();

    // R1: pin held high through reset never qualifies until seen low
    do_reset(2'b01);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R1", "no fault without prior low", {14'd0, fault_live}, 16'd0);
      @(negedge clk);
    end
    fault_pin = 2'b00; step(); @(negedge clk);
    fault_pin = 2'b01; step();
    check("R2", "one high only", {14'd0, fault_live}, 16'd0);
    @(negedge clk);
    step();
    check("R2", "armed then two highs", {14'd0, fault_live}, 16'd1);

    // R6: mask change follows without a clock edge
    #2;
    map_mask = {6'b000000, 6'b101000};
    #1;
    check("R6", "mask change immediate", {10'd0, pwm_disable}, {10'd0, 6'b101000});
    map_mask = {6'b110100, 6'b000111};
    #1;
    check("R6", "mask restored", {10'd0, pwm_disable}, {10'd0, 6'b000111});

    // table walk from a fresh reset
    do_reset(2'b00);
    for (int k = 0; k < NV; k++) begin
      fault_pin   = VEC[k][16:15];
      port_is_out = VEC[k][14:13];
      flag_clr    = VEC[k][12:11];
      cycle_start = VEC[k][10];
      step();
      check($sformatf("row%0d", k), "live", {14'd0, fault_live}, {14'd0, VEC[k][9:8]});
      check($sformatf("row%0d", k), "flag", {14'd0, fault_flag}, {14'd0, VEC[k][7:6]});
      check($sformatf("row%0d", k), "disable", {10'd0, pwm_disable}, {10'd0, VEC[k][5:0]});
      @(negedge clk);
    end

    // R8: swap modes; input1 now automatic and released with flag still set
    auto_mode = 2'b10;
    idle_inputs();
    fault_pin = 2'b10; step(); @(negedge clk);
    step(); @(negedge clk);
    fault_pin = 2'b00; cycle_start = 1'b0; step(); @(negedge clk);
    cycle_start = 1'b1; step();
    check("R8", "automatic release ignores flag", {10'd0, pwm_disable}, 16'd0);
    check("R8", "flag kept", {14'd0, fault_flag}, 16'd2);
    @(negedge clk);
    idle_inputs();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule